// File: doc/BRIEF.md
# Status Register Write-Protect Gate

This block decides whether a pending write to a serial memory's status register may go ahead. It combines an active-low hardware protect pin with a protect-enable flag kept in the status register itself. When the flag is clear, the pin is ignored. This lets a board tie the pin to ground and still reprogram the register. When the flag is set, a low pin refuses the write, and the pin also cancels the write if it falls while the command is still being clocked in.

The command decoder raises a one-cycle request once it has recognised a status-write opcode. The gate then holds the command open until chip select returns high. At that edge it either starts the internal write cycle with a one-cycle commit pulse, refuses it with a one-cycle abort pulse, or quietly drops a command whose framing was wrong. Once the internal cycle is running, the pin no longer matters. The cycle ends when the write engine reports completion.

The gate keeps the stored protect-enable flag itself. A commit loads the new flag value. Every gating decision uses the stored value, so a new value only governs the commands that follow it. The pin and chip select come from off chip and are passed through a synchroniser of configurable depth before any decision uses them.

Top module: `sr_wp_gate`

## Requirements
- R1: After reset the block is idle: commit_o=0, abort_o=0, busy_o=0, and wpen_o equals parameter WPEN_RST.
- R2: With the synchronised pin high, a request followed by a rising chip select with frame_ok=1 gives exactly one commit_o pulse one clock after that edge is seen. busy_o=1 then holds until one clock after cyc_done.
- R3: With the synchronised pin low and the stored flag 1, a request in idle gives one abort_o pulse on the next clock and no commit. commit_o and abort_o are never high together.
- R4: With the stored flag 0, a low pin has no effect: the write commits as in R2.
- R5: While a command is armed and chip select is still low, the synchronised pin falling with the stored flag 1 gives one abort_o pulse. The later chip-select rise then produces no commit.
- R6: While the internal write runs (busy_o=1), a low pin gives no abort and the write ends normally on cyc_done.
- R7: A commit loads wpen_new into wpen_o. The previously stored value alone governs the command being committed, and wpen_o changes at no other time.
- R8: A chip-select rise while armed with frame_ok=0 gives neither commit nor abort and leaves wpen_o unchanged.
- R9: wp_n and cs_n each pass through SYNC_STAGES flip-flops before use. A pin fall and a chip-select rise driven in the same cycle are seen together, and the write is refused.
- R10: A request arriving while busy_o=1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wp_n | input | 1 | Write-protect pin, active low, asynchronous |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sw_req | input | 1 | One-cycle strobe: status-write command decoded |
| frame_ok | input | 1 | Command ended on a byte boundary (sampled at deselect) |
| cyc_done | input | 1 | One-cycle strobe: internal write cycle finished |
| wpen_new | input | 1 | Protect-enable value carried by the command |
| commit_o | output | 1 | One-cycle pulse: start internal write, register updated |
| abort_o | output | 1 | One-cycle pulse: write refused by protection |
| wpen_o | output | 1 | Stored protect-enable flag |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
The bench builds the gate with SYNC_STAGES=2 and WPEN_RST=0. With that depth, driving the pin and chip select in the same cycle puts both edges in the same synchronised cycle, which exercises the tie case in R9. It also lets a pin fall during the armed window without racing the deselect. Starting with the flag clear, the bench first commits a set flag. This makes both flag values reachable in one run, so the same low-pin stimulus can be shown both refused and ignored.

// File: rtl/sr_wp_pkg.sv
// Package: shared state encoding for the status-write protect gate.
package sr_wp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_WRITING = 2'd2,
        ST_DONE    = 2'd3
    } gate_st_e;
endpackage

// File: rtl/sr_wp_sync.sv
// sr_wp_sync: multi-flop synchroniser for one asynchronous pin.
// Assumes: STAGES >= 1; the reset value is the pin's inactive level.
module sr_wp_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the raw pin into the first flop.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= RST_VAL;
                    else        chain_q[0] <= d_i;
                end
            end else begin : g_next
                // Pass the value one stage further along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= RST_VAL;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sr_wp_bit.sv
// sr_wp_bit: storage for the protect-enable flag.
// Assumes: load_i is a single-cycle strobe issued only on commit.
module sr_wp_bit #(
    parameter logic WPEN_RST = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic val_i,
    output logic wpen_q
);
    // Hold the flag; replace it only on a committed write.
    always_ff @(posedge clk) begin
        if (!rst_n)      wpen_q <= WPEN_RST;
        else if (load_i) wpen_q <= val_i;
    end

    // R7
    wpen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(wpen_q));
endmodule

// File: rtl/sr_wp_fsm.sv
// sr_wp_fsm: command-phase tracker that grants or refuses a status write.
// Assumes: wp_s and cs_s are already synchronised; sw_req, frame_ok,
// cyc_done are in the clk domain. Protection is judged against the stored
// flag only, and the pin is consulted while idle-requesting or armed.
module sr_wp_fsm
    import sr_wp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wp_s,
    input  logic cs_s,
    input  logic sw_req,
    input  logic frame_ok,
    input  logic cyc_done,
    input  logic wpen_i,
    output logic load_o,
    output logic commit_o,
    output logic abort_o,
    output logic busy_o
);
    gate_st_e state_q, state_d;
    logic     cs_prev_q;
    logic     cs_rise;
    logic     blocked;
    logic     commit_d, abort_d;

    assign cs_rise = cs_s && !cs_prev_q;
    assign blocked = !wp_s && wpen_i;

    // Next-state and pulse decision for the current cycle.
    always_comb begin
        state_d  = state_q;
        commit_d = 1'b0;
        abort_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (sw_req) begin
                    if (blocked) abort_d = 1'b1;
                    else         state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (cs_rise) begin
                    if (blocked) begin
                        abort_d = 1'b1;
                        state_d = ST_IDLE;
                    end else if (frame_ok) begin
                        commit_d = 1'b1;
                        state_d  = ST_WRITING;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else if (blocked) begin
                    abort_d = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_WRITING: begin
                if (cyc_done) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Register state, the previous chip-select level and the output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cs_prev_q <= 1'b1;
            commit_o  <= 1'b0;
            abort_o   <= 1'b0;
        end else begin
            state_q   <= state_d;
            cs_prev_q <= cs_s;
            commit_o  <= commit_d;
            abort_o   <= abort_d;
        end
    end

    assign load_o = commit_d;
    assign busy_o = (state_q == ST_WRITING) || (state_q == ST_DONE);

    // R3
    no_dual_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_o && abort_o));
    // R3
    abort_needs_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> ($past(wpen_i) && !$past(wp_s)));
    // R2
    commit_enters_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> (state_q == ST_WRITING));
    // R6
    no_abort_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITING) |=> !abort_o);
    // R8
    commit_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(frame_ok));
endmodule

// File: rtl/sr_wp_gate.sv
// sr_wp_gate: top of the status-register write-protect gate.
// Assumes: wp_n and cs_n are asynchronous board pins; other inputs come
// from the command decoder and write engine in the clk domain.
module sr_wp_gate #(
    parameter int   SYNC_STAGES = 2,
    parameter logic WPEN_RST    = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wp_n,
    input  logic cs_n,
    input  logic sw_req,
    input  logic frame_ok,
    input  logic cyc_done,
    input  logic wpen_new,
    output logic commit_o,
    output logic abort_o,
    output logic wpen_o,
    output logic busy_o
);
    logic wp_s, cs_s, load;

    sr_wp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wp_sync (
        .clk(clk), .rst_n(rst_n), .d_i(wp_n), .q_o(wp_s)
    );

    sr_wp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .d_i(cs_n), .q_o(cs_s)
    );

    sr_wp_bit #(.WPEN_RST(WPEN_RST)) u_wpen (
        .clk(clk), .rst_n(rst_n), .load_i(load), .val_i(wpen_new),
        .wpen_q(wpen_o)
    );

    sr_wp_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wp_s(wp_s), .cs_s(cs_s),
        .sw_req(sw_req), .frame_ok(frame_ok), .cyc_done(cyc_done),
        .wpen_i(wpen_o), .load_o(load), .commit_o(commit_o),
        .abort_o(abort_o), .busy_o(busy_o)
    );
endmodule

// File: tb/sr_wp_gate_bench.sv
module sr_wp_gate_bench;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wp_n = 1'b1, cs_n = 1'b1, sw_req = 1'b0, frame_ok = 1'b0;
    logic cyc_done = 1'b0, wpen_new = 1'b0;
    logic commit_o, abort_o, wpen_o, busy_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    string tag = "R1";

    always #5 clk = ~clk;

    sr_wp_gate #(.SYNC_STAGES(SYNC), .WPEN_RST(1'b0)) u_sr_wp_gate (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cs_n(cs_n),
        .sw_req(sw_req), .frame_ok(frame_ok), .cyc_done(cyc_done),
        .wpen_new(wpen_new), .commit_o(commit_o), .abort_o(abort_o),
        .wpen_o(wpen_o), .busy_o(busy_o)
    );

    // Behavioural reference: 0 idle, 1 armed, 2 writing, 3 done.
    int m_state = 0;
    bit m_commit = 0, m_abort = 0, m_wpen = 0, m_busy = 0, cs_prev = 1;
    bit wp_q[$] = '{1, 1};
    bit cs_q[$] = '{1, 1};

    always @(posedge clk) begin
        bit wp_s, cs_s, rise, blk;
        if (!rst_n) begin
            m_state = 0; m_commit = 0; m_abort = 0; m_wpen = 0; cs_prev = 1;
            wp_q = '{1, 1}; cs_q = '{1, 1};
        end else begin
            wp_s = wp_q[SYNC-1];
            cs_s = cs_q[SYNC-1];
            rise = cs_s && !cs_prev;
            blk  = !wp_s && m_wpen;
            m_commit = 0; m_abort = 0;
            if (m_state == 0) begin
                if (sw_req) begin
                    if (blk) m_abort = 1; else m_state = 1;
                end
            end else if (m_state == 1) begin
                if (rise) begin
                    if (blk) begin m_abort = 1; m_state = 0; end
                    else if (frame_ok) begin
                        m_commit = 1; m_state = 2; m_wpen = wpen_new;
                    end else m_state = 0;
                end else if (blk) begin m_abort = 1; m_state = 0; end
            end else if (m_state == 2) begin
                if (cyc_done) m_state = 3;
            end else m_state = 0;
            cs_prev = cs_s;
            wp_q.push_front(wp_n); void'(wp_q.pop_back());
            cs_q.push_front(cs_n); void'(cs_q.pop_back());
        end
        m_busy = (m_state >= 2);
    end

    task automatic chk(string what, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model shortly after each edge.
    always @(posedge clk) begin
        #2;
        if (!finished) begin
            chk("commit_o", commit_o, m_commit);
            chk("abort_o", abort_o, m_abort);
            chk("wpen_o", wpen_o, m_wpen);
            chk("busy_o", busy_o, m_busy);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req();
        sw_req = 1; cyc(1); sw_req = 0;
    endtask

    task automatic pulse_done();
        cyc_done = 1; cyc(1); cyc_done = 0;
    endtask

    task automatic summary();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired under %s", tag);
        summary();
    end

    initial begin
        tag = "R1"; cyc(4); rst_n = 1; cyc(3);
        // R2 with R7: pin high, commit loads flag 1
        tag = "R2"; cs_n = 0; cyc(3); pulse_req(); cyc(2);
        frame_ok = 1; wpen_new = 1; cs_n = 1; cyc(6);
        tag = "R7"; pulse_done(); cyc(4);
        // R3: flag set, pin low, request refused at once
        tag = "R3"; wp_n = 0; cyc(3); cs_n = 0; cyc(3); pulse_req(); cyc(2);
        cs_n = 1; cyc(4); wp_n = 1; cyc(3);
        // R5: pin falls while armed, later deselect does nothing
        tag = "R5"; cs_n = 0; cyc(3); pulse_req(); cyc(3); wp_n = 0; cyc(5);
        cs_n = 1; cyc(4); wp_n = 1; cyc(3);
        // R6 with R10: pin low and extra request during write; flag to 0
        tag = "R6"; cs_n = 0; wpen_new = 0; cyc(3); pulse_req(); cyc(2);
        cs_n = 1; cyc(4); wp_n = 0; cyc(2);
        tag = "R10"; pulse_req(); cyc(3);
        tag = "R6"; pulse_done(); cyc(4);
        // R4: flag clear, pin low ignored, commit sets flag again
        tag = "R4"; cs_n = 0; wpen_new = 1; cyc(3); pulse_req(); cyc(2);
        cs_n = 1; cyc(4); pulse_done(); cyc(4); wp_n = 1; cyc(3);
        // R8: misframed command dropped
        tag = "R8"; frame_ok = 0; wpen_new = 0; cs_n = 0; cyc(3); pulse_req();
        cyc(2); cs_n = 1; cyc(6); frame_ok = 1;
        // R9: pin fall and deselect in the same cycle -> refused
        tag = "R9"; cs_n = 0; cyc(3); pulse_req(); cyc(2);
        wp_n = 0; cs_n = 1; cyc(6); wp_n = 1; cyc(4);
        summary();
    end
endmodule